// File: doc/BRIEF.md
# SIMD Memory Element Formatter

This block sits between a memory data port and a bank of 32-bit register words and reshapes the data of one vector load or store. A request carries a direction, a transfer length in bytes, an element width, a byte-order mode, a base address and an immediate. For a load, the memory bytes are reordered element by element and then cut into 32-bit words. Every byte past the transfer length is cleared, and a write enable is raised for each word the transfer touches. For a store, the register words are packed into a byte stream, reordered element by element in the same way, and given a byte-enable mask.

The request side uses a valid/ready handshake. All results come from registers one clock after the request is accepted. An element-width and length pair that the block does not support raises an error flag. In that case no word enable and no byte enable is raised. The effective address is the base plus the zero-extended immediate.

Top module: `vmem_fmt`

## Requirements
- R1: `req_esize` encodes the element width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. A pair is legal when the length is 1 to 4 elements totalling at most 16 bytes, or when the length is 8 or 16 bytes. Any other pair, including length 0, gives `out_err` = 1 with `reg_we` = 0 and `mem_be` = 0.
- R2: For a legal load, `reg_we` bit k is set exactly for words k < (length + 3) / 4, rounded down.
- R3: For a load, every output byte at index length or above is zero. This covers the upper bytes of the last partial word and all unused words. Byte i of `mem_rdata` sits at bits 8i+7:8i, and word k of `reg_wdata` sits at bits 32k+31:32k.
- R4: With `req_big` = 1, the bytes of each element are reversed. Byte j of element e takes byte (E-1-j) of that element, where E is the element width. With `req_big` = 0, bytes keep their positions.
- R5: For a load, the reordering is applied to the memory bytes before they are split into words. A word can therefore receive bytes from the far end of an element that spans two words.
- R6: For a store, word k of `reg_rdata` supplies bytes 4k to 4k+3 least significant first, and the R4 reordering is then applied. `mem_be` bit i is set exactly for i < length. Bytes of `mem_wdata` at or above the length are zero. `reg_we` stays 0.
- R7: `out_addr` equals `req_base` plus the zero-extended `req_imm`, modulo 2^AW.
- R8: `out_valid` is high exactly one cycle after a request is accepted. When `out_valid` is low, `out_err`, `reg_we` and `mem_be` are zero.
- R9: While `rst` is high, all outputs, including `req_ready`, are zero. `req_ready` is 1 from the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_big | input | 1 | 1 = big-endian element order |
| req_esize | input | 2 | Element width code |
| req_size | input | 5 | Transfer length in bytes |
| req_base | input | AW | Base address |
| req_imm | input | IW | Unsigned address offset |
| mem_rdata | input | 128 | Load byte buffer from memory |
| reg_rdata | input | 128 | Four register words for a store |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Illegal size pair |
| out_addr | output | AW | Effective address |
| reg_we | output | 4 | Per-word register write enables |
| reg_wdata | output | 128 | Register words for a load |
| mem_be | output | 16 | Store byte enables |
| mem_wdata | output | 128 | Store byte buffer |

## Verification
Element reordering and tail masking act on the same bytes in the same cycle. This happens whenever the last element of a transfer ends partway through a word, as in a 6-byte load of 2-byte elements in big-endian mode. The bench applies such lengths with both byte orders and compares every output byte against a per-element reference. It checks that the swapped pair lands inside the kept bytes and that the following bytes are cleared. Illegal pairs are mixed into the same random stream, so the error path and the formatting path are exercised on neighbouring cycles.

// File: rtl/vmem_fmt_pkg.sv
`timescale 1ns/1ps
package vmem_fmt_pkg;

    localparam int BUF_BYTES = 16;
    localparam int WORD_BYTES = 4;
    localparam int BUF_WORDS = BUF_BYTES / WORD_BYTES;
    localparam int SIZE_W = $clog2(BUF_BYTES) + 1;

    typedef enum logic [1:0] {
        ESZ_B1 = 2'd0,
        ESZ_B2 = 2'd1,
        ESZ_B4 = 2'd2,
        ESZ_B8 = 2'd3
    } esize_e;

    typedef struct packed {
        logic                   legal;
        logic [BUF_WORDS-1:0]   word_en;
        logic [BUF_BYTES-1:0]   byte_keep;
    } xfer_plan_t;

    function automatic logic [SIZE_W:0] elem_bytes(esize_e e);
        return (SIZE_W+1)'(1) << e;
    endfunction

    function automatic logic pair_legal(esize_e e, logic [SIZE_W-1:0] sz);
        logic [SIZE_W:0] eb;
        logic [SIZE_W:0] szx;
        logic by_count;
        eb  = elem_bytes(e);
        szx = {1'b0, sz};
        by_count = (szx != '0) && ((szx & (eb - 1'b1)) == '0)
                   && (szx <= (eb << 2)) && (szx <= (SIZE_W+1)'(BUF_BYTES));
        return by_count || (szx == (SIZE_W+1)'(8)) || (szx == (SIZE_W+1)'(16));
    endfunction

endpackage

// File: rtl/vmem_fmt_decode.sv
`timescale 1ns/1ps
module vmem_fmt_decode
    import vmem_fmt_pkg::*;
(
    input  esize_e              esize,
    input  logic [SIZE_W-1:0]   size,
    output xfer_plan_t          plan
);
    logic legal;

    assign legal = pair_legal(esize, size);

    for (genvar i = 0; i < BUF_BYTES; i++) begin : g_keep
        assign plan.byte_keep[i] = legal && (SIZE_W'(i) < size);
    end

    for (genvar k = 0; k < BUF_WORDS; k++) begin : g_word
        assign plan.word_en[k] = legal && (SIZE_W'(k * WORD_BYTES) < size);
    end

    assign plan.legal = legal;
endmodule

// File: rtl/vmem_fmt_swap.sv
`timescale 1ns/1ps
module vmem_fmt_swap
    import vmem_fmt_pkg::*;
#(
    parameter int NB = BUF_BYTES
) (
    input  logic [8*NB-1:0] din,
    input  esize_e          esize,
    input  logic            big,
    output logic [8*NB-1:0] dout
);
    localparam int IDXW = $clog2(NB);

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [IDXW-1:0] sel;
        always_comb begin
            sel = IDXW'(i);
            if (big) begin
                case (esize)
                    ESZ_B2:  sel = IDXW'(i) ^ IDXW'(1);
                    ESZ_B4:  sel = IDXW'(i) ^ IDXW'(3);
                    ESZ_B8:  sel = IDXW'(i) ^ IDXW'(7);
                    default: sel = IDXW'(i);
                endcase
            end
        end
        assign dout[8*i +: 8] = din[8*sel +: 8];
    end
endmodule

// File: rtl/vmem_fmt_agen.sv
`timescale 1ns/1ps
module vmem_fmt_agen #(
    parameter int AW = 32,
    parameter int IW = 12
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] imm,
    output logic [AW-1:0] addr
);
    localparam int PADW = AW - IW;

    assign addr = base + {{PADW{1'b0}}, imm};
endmodule

// File: rtl/vmem_fmt.sv
`timescale 1ns/1ps
module vmem_fmt
    import vmem_fmt_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_store,
    input  logic                     req_big,
    input  logic [1:0]               req_esize,
    input  logic [SIZE_W-1:0]        req_size,
    input  logic [AW-1:0]            req_base,
    input  logic [IW-1:0]            req_imm,
    input  logic [8*BUF_BYTES-1:0]   mem_rdata,
    input  logic [8*BUF_BYTES-1:0]   reg_rdata,
    output logic                     out_valid,
    output logic                     out_err,
    output logic [AW-1:0]            out_addr,
    output logic [BUF_WORDS-1:0]     reg_we,
    output logic [8*BUF_BYTES-1:0]   reg_wdata,
    output logic [BUF_BYTES-1:0]     mem_be,
    output logic [8*BUF_BYTES-1:0]   mem_wdata
);
    localparam int DW = 8 * BUF_BYTES;

    esize_e             esz;
    xfer_plan_t         plan;
    logic [DW-1:0]      swap_in;
    logic [DW-1:0]      swapped;
    logic [DW-1:0]      kept;
    logic [AW-1:0]      addr_d;
    logic               ready_q;
    logic               fire;

    assign esz       = esize_e'(req_esize);
    assign req_ready = ready_q;
    assign fire      = req_valid && ready_q;

    vmem_fmt_decode u_decode (
        .esize (esz),
        .size  (req_size),
        .plan  (plan)
    );

    // Store words pack little-endian, so the packed word vector is already a byte stream.
    assign swap_in = req_store ? reg_rdata : mem_rdata;

    vmem_fmt_swap #(.NB(BUF_BYTES)) u_swap (
        .din   (swap_in),
        .esize (esz),
        .big   (req_big),
        .dout  (swapped)
    );

    for (genvar i = 0; i < BUF_BYTES; i++) begin : g_mask
        assign kept[8*i +: 8] = plan.byte_keep[i] ? swapped[8*i +: 8] : 8'h00;
    end

    vmem_fmt_agen #(.AW(AW), .IW(IW)) u_agen (
        .base (req_base),
        .imm  (req_imm),
        .addr (addr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q   <= 1'b0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_addr  <= '0;
            reg_we    <= '0;
            reg_wdata <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else begin
            ready_q   <= 1'b1;
            out_valid <= fire;
            out_err   <= fire && !plan.legal;
            out_addr  <= fire ? addr_d : '0;
            reg_we    <= (fire && !req_store) ? plan.word_en : '0;
            reg_wdata <= (fire && !req_store) ? kept : '0;
            mem_be    <= (fire && req_store) ? plan.byte_keep : '0;
            mem_wdata <= (fire && req_store) ? kept : '0;
        end
    end

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (reg_we == '0) && (mem_be == '0)); // R1

    AST_WE_CONTIG: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(reg_we + 1'b1)); // R2

    for (genvar k = 0; k < BUF_WORDS; k++) begin : g_chk_word
        AST_UNUSED_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
            !reg_we[k] |-> (reg_wdata[32*k +: 32] == '0)); // R3
    end

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !((|reg_we) && (|mem_be))); // R6

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> out_valid); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_err && (reg_we == '0) && (mem_be == '0)); // R8
endmodule

// File: tb/tb_vmem_fmt.sv
`timescale 1ns/1ps
module tb_vmem_fmt;
    localparam int AW = 32;
    localparam int IW = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic           req_store = 1'b0;
    logic           req_big = 1'b0;
    logic [1:0]     req_esize = 2'd0;
    logic [4:0]     req_size = 5'd0;
    logic [AW-1:0]  req_base = '0;
    logic [IW-1:0]  req_imm = '0;
    logic [127:0]   mem_rdata = '0;
    logic [127:0]   reg_rdata = '0;
    logic           out_valid;
    logic           out_err;
    logic [AW-1:0]  out_addr;
    logic [3:0]     reg_we;
    logic [127:0]   reg_wdata;
    logic [15:0]    mem_be;
    logic [127:0]   mem_wdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vmem_fmt #(.AW(AW), .IW(IW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_big(req_big), .req_esize(req_esize),
        .req_size(req_size), .req_base(req_base), .req_imm(req_imm),
        .mem_rdata(mem_rdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
        .out_err(out_err), .out_addr(out_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .mem_be(mem_be), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_legal(int eb, int sz);
        bit ok = 0;
        for (int c = 1; c <= 4; c++) if (c * eb == sz && sz <= 16) ok = 1;
        if (sz == 8 || sz == 16) ok = 1;
        return ok;
    endfunction

    function automatic logic [127:0] ref_fmt(logic [127:0] src, int eb, bit big, int sz);
        logic [127:0] r = '0;
        for (int b = 0; b < sz; b++) begin
            int ebase = (b / eb) * eb;
            int off = b % eb;
            int s = big ? (ebase + eb - 1 - off) : b;
            r[8*b +: 8] = src[8*s +: 8];
        end
        return r;
    endfunction

    task automatic run(input bit st, input bit big, input int es, input int sz,
                       input logic [AW-1:0] base, input logic [IW-1:0] imm,
                       input logic [127:0] data);
        int eb = 1 << es;
        bit lg = ref_legal(eb, sz);
        logic [127:0] exp_d;
        logic [3:0] exp_we = '0;
        logic [15:0] exp_be = '0;
        logic [AW-1:0] exp_a = base + AW'(imm);
        exp_d = lg ? ref_fmt(data, eb, big, sz) : '0;
        for (int k = 0; k < 4; k++) if (lg && !st && 4 * k < sz) exp_we[k] = 1'b1;
        for (int i = 0; i < 16; i++) if (lg && st && i < sz) exp_be[i] = 1'b1;
        req_valid = 1'b1; req_store = st; req_big = big;
        req_esize = 2'(es); req_size = 5'(sz); req_base = base; req_imm = imm;
        if (st) begin reg_rdata = data; mem_rdata = ~data; end
        else begin mem_rdata = data; reg_rdata = ~data; end
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid === 1'b1, "R8", "out_valid", 128'(out_valid), 128'(1));
        chk(out_err === !lg, "R1", "out_err", 128'(out_err), 128'(!lg));
        chk(out_addr === exp_a, "R7", "out_addr", 128'(out_addr), 128'(exp_a));
        if (st) begin
            chk(mem_be === exp_be, "R6", "mem_be", 128'(mem_be), 128'(exp_be));
            chk(mem_wdata === exp_d, big ? "R4/R6" : "R6", "mem_wdata", mem_wdata, exp_d);
            chk(reg_we === 4'b0, "R6", "reg_we on store", 128'(reg_we), 128'(0));
        end else begin
            chk(reg_we === exp_we, lg ? "R2" : "R1", "reg_we", 128'(reg_we), 128'(exp_we));
            chk(reg_wdata === exp_d, big ? "R4/R5" : "R3", "reg_wdata", reg_wdata, exp_d);
            chk(mem_be === 16'b0, "R6", "mem_be on load", 128'(mem_be), 128'(0));
        end
    endtask

    task automatic idle_check();
        @(posedge clk); @(negedge clk);
        chk(out_valid === 1'b0 && out_err === 1'b0 && reg_we === 4'b0 && mem_be === 16'b0,
            "R8", "idle outputs", {out_valid, out_err, reg_we, mem_be}, 128'(0));
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int sizes[8] = '{1, 2, 3, 4, 6, 8, 12, 16};
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b0 && out_valid === 1'b0 && reg_we === 4'b0 && mem_be === 16'b0
            && reg_wdata === '0 && out_addr === '0, "R9", "reset state",
            {req_ready, out_valid, reg_we, mem_be}, 128'(0));
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(req_ready === 1'b1, "R9", "ready after reset", 128'(req_ready), 128'(1));

        // R3 R4 R5: 2-byte elements, 6 bytes, big: swap and tail mask in one word
        run(0, 1, 1, 6, 32'h1000, 12'h010, 128'hFFEEDDCCBBAA99887766554433221100);
        // R3: 3 single bytes
        run(0, 0, 0, 3, 32'h2000, 12'h004, 128'hFFEEDDCCBBAA99887766554433221100);
        // R2: 12 bytes of 4-byte elements, little
        run(0, 0, 2, 12, 32'h3000, 12'hFFF, 128'h0F0E0D0C0B0A09080706050403020100);
        // R5: 8-byte element spans two words, big
        run(0, 1, 3, 16, 32'h4000, 12'h000, 128'h0F0E0D0C0B0A09080706050403020100);
        // R6: store 16 bytes, 8-byte elements, big
        run(1, 1, 3, 16, 32'h5000, 12'h008, 128'h0F0E0D0C0B0A09080706050403020100);
        // R6: store 6 bytes, 2-byte elements, big
        run(1, 1, 1, 6, 32'h5100, 12'h002, 128'hFFEEDDCCBBAA99887766554433221100);
        // R1: illegal pairs
        run(0, 0, 2, 6, 32'h6000, 12'h001, 128'h1);
        run(1, 1, 3, 4, 32'h6000, 12'h001, 128'h2);
        run(0, 0, 0, 0, 32'h6000, 12'h001, 128'h3);
        // R1: 8 bytes of single-byte elements is legal
        run(0, 1, 0, 8, 32'h7000, 12'h000, 128'hFFEEDDCCBBAA99887766554433221100);
        // R7: address wraps
        run(0, 0, 2, 4, 32'hFFFF_FFFF, 12'h001, 128'h44332211);
        idle_check();

        for (int n = 0; n < 300; n++) begin
            int es = int'($urandom % 4);
            int sz = ($urandom % 10 < 7) ? sizes[$urandom % 8] : int'($urandom % 32);
            logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
            run(bit'($urandom % 2), bit'($urandom % 2), es, sz, AW'($urandom), IW'($urandom), d);
            if (n % 17 == 0) idle_check();
        end

        // R9: reset while a result is held
        run(0, 0, 2, 16, 32'h8000, 12'h0, {4{32'hDEADBEEF}});
        req_valid = 1'b1;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(out_valid === 1'b0 && reg_we === 4'b0 && reg_wdata === '0 && req_ready === 1'b0,
            "R9", "outputs cleared by reset", reg_wdata, 128'(0));
        req_valid = 1'b0;
        rst = 1'b0;
        @(posedge clk); @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule